// File: doc/BRIEF.md
# Cache Page Flush and Invalidate Sequencer

This block is a maintenance engine that sits beside a write-back, set-associative cache whose lines carry a four-state coherence code. Software hands it either a page request or a whole-cache request. A page request carries a linear page number and a select bit. The bit picks between flushing the page, which writes back dirty lines and then drops them, and invalidating the page, which drops the lines with no writeback. The two whole-cache requests either write back every dirty line before clearing the cache, or clear it with no writeback.

A page request first goes to a translation port. If translation faults, the engine records the fault in a sticky status flag, leaves the cache untouched and raises nothing else. Otherwise it steps through every set that the physical page maps to. For each set it reads the tags and states of all ways and offers each affected dirty line on a ready/valid writeback port. Only after those writebacks does it write the Invalid state into the affected ways. A busy flag covers the whole run, and commands that arrive during a run are dropped.

Top module: `pgm_maint_engine`

## Requirements
- R1: Line state codes are Invalid=00, Shared=01, Exclusive=10 and Modified=11. A page request maps the physical page number P to cache sets {P[HI_W-1:0], k} for every k from 0 to 2^(PAGE_BITS-LINE_BITS)-1, and compares against tag P[VPN_W-1:HI_W]. Only ways that are not Invalid and whose tag matches are affected. All other sets and ways keep their state.
- R2: When the select bit is 0 (flush), each affected Modified line is written back with address {tag, set index}. Writebacks go in ascending set order and, within a set, in ascending way order. Every affected way of the page ends Invalid.
- R3: When the select bit is 1 (invalidate), every affected way ends Invalid and the writeback port never asserts valid.
- R4: If the translation port answers with a fault, the fault flag reads 1 from the next cycle. Busy drops in that same cycle, and no tag write or writeback is issued for that request.
- R5: Accepting a page request clears the fault flag, so the flag reads 0 after a successful page operation. Whole-cache requests leave the flag as it was.
- R6: Busy is 1 from the cycle after a request is accepted until the cycle after the last tag write. Any request presented while busy is 1 is dropped and has no effect, including one presented in the same cycle as the final tag write.
- R7: The whole-cache writeback-invalidate request writes back every Modified line in every set, in set then way order, and leaves every line Invalid.
- R8: The whole-cache invalidate request leaves every line Invalid without any writeback.
- R9: Shared and Exclusive lines are made Invalid without a writeback in every mode.
- R10: While wb_valid is 1 and wb_ready is 0, wb_valid and wb_addr hold. A set's tag write happens only after all of that set's writebacks have been accepted.
- R11: If several requests are presented in one idle cycle, the page request wins over writeback-invalidate, and writeback-invalidate wins over invalidate-only. The losing requests are dropped.
- R12: The translation request stays asserted, with a stable page number, until a response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_page_wr | input | 1 | Page request strobe |
| cmd_page_inv | input | 1 | Page request select: 0 flush, 1 invalidate |
| cmd_page_vpn | input | VPN_W (12) | Linear page number of the request |
| cmd_all_wbinv | input | 1 | Whole-cache writeback-invalidate strobe |
| cmd_all_inv | input | 1 | Whole-cache invalidate strobe |
| stat_busy | output | 1 | Run in progress |
| stat_pf | output | 1 | Sticky translation-fault flag |
| xl_req | output | 1 | Translation request |
| xl_vpn | output | VPN_W (12) | Page number to translate |
| xl_rsp_valid | input | 1 | Translation response valid |
| xl_fault | input | 1 | Translation faulted |
| xl_ppn | input | VPN_W (12) | Translated physical page number |
| tag_rd_en | output | 1 | Tag array read strobe |
| tag_rd_idx | output | IDX_W (6) | Set to read |
| tag_rd_tags | input | WAYS*TAG_W (20) | Tags of all ways, one cycle after the read |
| tag_rd_states | input | WAYS*2 (4) | Line states of all ways, one cycle after the read |
| tag_wr_en | output | 1 | Write Invalid into the masked ways |
| tag_wr_idx | output | IDX_W (6) | Set to write |
| tag_wr_mask | output | WAYS (2) | Ways to invalidate |
| wb_valid | output | 1 | Writeback request valid |
| wb_ready | input | 1 | Writeback request accepted |
| wb_addr | output | TAG_W+IDX_W (16) | Line address {tag, set} to write back |
| wb_way | output | WAY_W (1) | Way holding the line |

## Verification
Two things can land in the same cycle: the final tag write of a page run and a fresh request strobe from software. The bench watches for the read of the page's last set, waits two cycles so that the invalidate-only run reaches its last tag write, and presents a whole-cache invalidate in exactly that cycle. It then checks that the write really was in that cycle, that busy falls and stays low, and that lines outside the page are still valid. A second overlap is a writeback offered while the responder holds ready low. Ready follows a pseudo-random pattern, and the scoreboard confirms that each accepted line was still Modified in the cache model when its handshake completed.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
   typedef enum logic [1:0] {
      LS_I = 2'b00,
      LS_S = 2'b01,
      LS_E = 2'b10,
      LS_M = 2'b11
   } line_st_e;

   typedef enum logic [1:0] {
      OP_PG_FLUSH = 2'd0,
      OP_PG_INV   = 2'd1,
      OP_ALL_WBI  = 2'd2,
      OP_ALL_INV  = 2'd3
   } maint_op_e;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_XLATE = 3'd1,
      SQ_READ  = 3'd2,
      SQ_CMP   = 3'd3,
      SQ_WB    = 3'd4,
      SQ_INV   = 3'd5
   } seq_st_e;
endpackage

// File: rtl/pgm_cmd_arb.sv
module pgm_cmd_arb
   import pgm_pkg::*;
#(
   parameter int VPN_W = 12
) (
   input  logic             idle,
   input  logic             cmd_page_wr,
   input  logic             cmd_page_inv,
   input  logic [VPN_W-1:0] cmd_page_vpn,
   input  logic             cmd_all_wbinv,
   input  logic             cmd_all_inv,
   output logic             start,
   output maint_op_e        start_op,
   output logic [VPN_W-1:0] start_vpn
);
   always_comb begin
      start     = 1'b0;
      start_op  = OP_ALL_INV;
      start_vpn = cmd_page_vpn;
      if (idle) begin
         if (cmd_page_wr) begin
            start    = 1'b1;
            start_op = cmd_page_inv ? OP_PG_INV : OP_PG_FLUSH;
         end else if (cmd_all_wbinv) begin
            start    = 1'b1;
            start_op = OP_ALL_WBI;
         end else if (cmd_all_inv) begin
            start    = 1'b1;
            start_op = OP_ALL_INV;
         end
      end
   end
endmodule

// File: rtl/pgm_way_classify.sv
module pgm_way_classify
   import pgm_pkg::*;
#(
   parameter int WAYS  = 2,
   parameter int TAG_W = 10
) (
   input  logic [WAYS*TAG_W-1:0] rd_tags,
   input  logic [WAYS*2-1:0]     rd_states,
   input  logic [TAG_W-1:0]      cmp_tag,
   input  logic                  match_all,
   input  logic                  want_wb,
   output logic [WAYS-1:0]       hit_mask,
   output logic [WAYS-1:0]       wb_mask
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      line_st_e st;
      logic     tag_eq;
      assign st          = line_st_e'(rd_states[w*2 +: 2]);
      assign tag_eq      = (rd_tags[w*TAG_W +: TAG_W] == cmp_tag);
      assign hit_mask[w] = (st != LS_I) && (match_all || tag_eq);
      assign wb_mask[w]  = hit_mask[w] && want_wb && (st == LS_M);
   end
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq
   import pgm_pkg::*;
#(
   parameter int WAYS   = 2,
   parameter int TAG_W  = 10,
   parameter int IDX_W  = 6,
   parameter int PIDX_W = 4,
   parameter int VPN_W  = 12,
   parameter int WAY_W  = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  maint_op_e              start_op,
   input  logic [VPN_W-1:0]       start_vpn,
   output logic                   busy,
   output logic                   pf,
   output logic                   mode_page,
   output logic                   mode_no_wb,
   output logic                   xl_req,
   output logic [VPN_W-1:0]       xl_vpn,
   input  logic                   xl_rsp_valid,
   input  logic                   xl_fault,
   input  logic [VPN_W-1:0]       xl_ppn,
   output logic                   tag_rd_en,
   output logic [IDX_W-1:0]       idx,
   input  logic [WAYS*TAG_W-1:0]  rd_tags,
   input  logic [WAYS-1:0]        hit_mask,
   input  logic [WAYS-1:0]        wb_mask,
   output logic [TAG_W-1:0]       page_tag,
   output logic                   match_all,
   output logic                   want_wb,
   output logic                   tag_wr_en,
   output logic [WAYS-1:0]        tag_wr_mask,
   output logic                   wb_valid,
   input  logic                   wb_ready,
   output logic [TAG_W+IDX_W-1:0] wb_addr,
   output logic [WAY_W-1:0]       wb_way
);
   localparam int HI_W = IDX_W - PIDX_W;

   seq_st_e              st_q;
   maint_op_e            op_q;
   logic [VPN_W-1:0]     vpn_q;
   logic [WAYS*TAG_W-1:0] tags_q;
   logic [WAYS-1:0]      hit_q, wbp_q, wb_sel;
   logic                 last_set;

   assign busy       = (st_q != SQ_IDLE);
   assign mode_page  = (op_q == OP_PG_FLUSH) || (op_q == OP_PG_INV);
   assign match_all  = !mode_page;
   assign want_wb    = (op_q == OP_PG_FLUSH) || (op_q == OP_ALL_WBI);
   assign mode_no_wb = busy && !want_wb;
   assign xl_req     = (st_q == SQ_XLATE);
   assign xl_vpn     = vpn_q;
   assign tag_rd_en  = (st_q == SQ_READ);
   assign tag_wr_en  = (st_q == SQ_INV) && (|hit_q);
   assign tag_wr_mask = hit_q;
   assign wb_valid   = (st_q == SQ_WB);
   assign last_set   = mode_page ? (&idx[PIDX_W-1:0]) : (&idx);

   always_comb begin
      logic found;
      found  = 1'b0;
      wb_way = '0;
      wb_sel = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (wbp_q[w] && !found) begin
            found     = 1'b1;
            wb_way    = WAY_W'(w);
            wb_sel[w] = 1'b1;
         end
      end
   end

   assign wb_addr = {tags_q[wb_way*TAG_W +: TAG_W], idx};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= SQ_IDLE;
         op_q     <= OP_ALL_INV;
         vpn_q    <= '0;
         idx      <= '0;
         page_tag <= '0;
         tags_q   <= '0;
         hit_q    <= '0;
         wbp_q    <= '0;
         pf       <= 1'b0;
      end else begin
         case (st_q)
            SQ_IDLE: if (start) begin
               op_q  <= start_op;
               vpn_q <= start_vpn;
               if ((start_op == OP_PG_FLUSH) || (start_op == OP_PG_INV)) begin
                  pf   <= 1'b0;
                  st_q <= SQ_XLATE;
               end else begin
                  idx  <= '0;
                  st_q <= SQ_READ;
               end
            end
            SQ_XLATE: if (xl_rsp_valid) begin
               if (xl_fault) begin
                  pf   <= 1'b1;
                  st_q <= SQ_IDLE;
               end else begin
                  page_tag <= xl_ppn[VPN_W-1:HI_W];
                  idx      <= {xl_ppn[HI_W-1:0], {PIDX_W{1'b0}}};
                  st_q     <= SQ_READ;
               end
            end
            SQ_READ: st_q <= SQ_CMP;
            SQ_CMP: begin
               tags_q <= rd_tags;
               hit_q  <= hit_mask;
               wbp_q  <= wb_mask;
               st_q   <= (|wb_mask) ? SQ_WB : SQ_INV;
            end
            SQ_WB: if (wb_ready) begin
               wbp_q <= wbp_q & ~wb_sel;
               if ((wbp_q & ~wb_sel) == '0) st_q <= SQ_INV;
            end
            SQ_INV: begin
               if (last_set) st_q <= SQ_IDLE;
               else begin
                  idx  <= idx + 1'b1;
                  st_q <= SQ_READ;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pgm_maint_engine.sv
module pgm_maint_engine
   import pgm_pkg::*;
#(
   parameter int LA_W      = 20,
   parameter int PAGE_BITS = 8,
   parameter int LINE_BITS = 4,
   parameter int SETS      = 64,
   parameter int WAYS      = 2,
   localparam int IDX_W    = $clog2(SETS),
   localparam int VPN_W    = LA_W - PAGE_BITS,
   localparam int PIDX_W   = PAGE_BITS - LINE_BITS,
   localparam int HI_W     = IDX_W - PIDX_W,
   localparam int TAG_W    = LA_W - LINE_BITS - IDX_W,
   localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_page_wr,
   input  logic                   cmd_page_inv,
   input  logic [VPN_W-1:0]       cmd_page_vpn,
   input  logic                   cmd_all_wbinv,
   input  logic                   cmd_all_inv,
   output logic                   stat_busy,
   output logic                   stat_pf,
   output logic                   xl_req,
   output logic [VPN_W-1:0]       xl_vpn,
   input  logic                   xl_rsp_valid,
   input  logic                   xl_fault,
   input  logic [VPN_W-1:0]       xl_ppn,
   output logic                   tag_rd_en,
   output logic [IDX_W-1:0]       tag_rd_idx,
   input  logic [WAYS*TAG_W-1:0]  tag_rd_tags,
   input  logic [WAYS*2-1:0]      tag_rd_states,
   output logic                   tag_wr_en,
   output logic [IDX_W-1:0]       tag_wr_idx,
   output logic [WAYS-1:0]        tag_wr_mask,
   output logic                   wb_valid,
   input  logic                   wb_ready,
   output logic [TAG_W+IDX_W-1:0] wb_addr,
   output logic [WAY_W-1:0]       wb_way
);
   if ((1 << IDX_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two");
   end
   if (PIDX_W < 1 || HI_W < 1) begin : g_bad_page
      $error("page must span more than one line and less than one way");
   end
   if (TAG_W < 1 || WAYS < 1) begin : g_bad_geom
      $error("address too narrow for the cache geometry");
   end

   logic                  start;
   maint_op_e             start_op;
   logic [VPN_W-1:0]      start_vpn;
   logic [IDX_W-1:0]      cur_idx;
   logic [WAYS-1:0]       hit_mask, wb_mask;
   logic [TAG_W-1:0]      page_tag;
   logic                  match_all, want_wb;
   logic                  mode_page, mode_no_wb;

   assign tag_rd_idx = cur_idx;
   assign tag_wr_idx = cur_idx;

   pgm_cmd_arb #(.VPN_W(VPN_W)) u_arb (
      .idle          (!stat_busy),
      .cmd_page_wr   (cmd_page_wr),
      .cmd_page_inv  (cmd_page_inv),
      .cmd_page_vpn  (cmd_page_vpn),
      .cmd_all_wbinv (cmd_all_wbinv),
      .cmd_all_inv   (cmd_all_inv),
      .start         (start),
      .start_op      (start_op),
      .start_vpn     (start_vpn)
   );

   pgm_way_classify #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cls (
      .rd_tags   (tag_rd_tags),
      .rd_states (tag_rd_states),
      .cmp_tag   (page_tag),
      .match_all (match_all),
      .want_wb   (want_wb),
      .hit_mask  (hit_mask),
      .wb_mask   (wb_mask)
   );

   pgm_seq #(
      .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W),
      .PIDX_W(PIDX_W), .VPN_W(VPN_W), .WAY_W(WAY_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .start_op     (start_op),
      .start_vpn    (start_vpn),
      .busy         (stat_busy),
      .pf           (stat_pf),
      .mode_page    (mode_page),
      .mode_no_wb   (mode_no_wb),
      .xl_req       (xl_req),
      .xl_vpn       (xl_vpn),
      .xl_rsp_valid (xl_rsp_valid),
      .xl_fault     (xl_fault),
      .xl_ppn       (xl_ppn),
      .tag_rd_en    (tag_rd_en),
      .idx          (cur_idx),
      .rd_tags      (tag_rd_tags),
      .hit_mask     (hit_mask),
      .wb_mask      (wb_mask),
      .page_tag     (page_tag),
      .match_all    (match_all),
      .want_wb      (want_wb),
      .tag_wr_en    (tag_wr_en),
      .tag_wr_mask  (tag_wr_mask),
      .wb_valid     (wb_valid),
      .wb_ready     (wb_ready),
      .wb_addr      (wb_addr),
      .wb_way       (wb_way)
   );
endmodule

// File: rtl/pgm_maint_chk.sv
module pgm_maint_chk #(
   parameter int VPN_W = 12,
   parameter int AW    = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stat_busy,
   input logic             stat_pf,
   input logic             xl_req,
   input logic [VPN_W-1:0] xl_vpn,
   input logic             xl_rsp_valid,
   input logic             xl_fault,
   input logic             tag_rd_en,
   input logic             tag_wr_en,
   input logic             wb_valid,
   input logic             wb_ready,
   input logic [AW-1:0]    wb_addr,
   input logic             mode_page,
   input logic             mode_no_wb
);
   p_wb_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));

   p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_busy |-> !tag_wr_en && !tag_rd_en && !wb_valid && !xl_req);

   p_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xl_req && xl_rsp_valid && xl_fault |=> stat_pf && !stat_busy && !tag_wr_en);

   p_pf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_busy) && mode_page |-> !stat_pf);

   p_xl_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      xl_req && !xl_rsp_valid |=> xl_req && $stable(xl_vpn));

   p_no_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_no_wb |-> !wb_valid);
endmodule

bind pgm_maint_engine pgm_maint_chk #(.VPN_W(VPN_W), .AW(TAG_W+IDX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .stat_busy    (stat_busy),
   .stat_pf      (stat_pf),
   .xl_req       (xl_req),
   .xl_vpn       (xl_vpn),
   .xl_rsp_valid (xl_rsp_valid),
   .xl_fault     (xl_fault),
   .tag_rd_en    (tag_rd_en),
   .tag_wr_en    (tag_wr_en),
   .wb_valid     (wb_valid),
   .wb_ready     (wb_ready),
   .wb_addr      (wb_addr),
   .mode_page    (mode_page),
   .mode_no_wb   (mode_no_wb)
);

// File: tb/sim_pgm_maint_engine.sv
`timescale 1ns/1ps
module sim_pgm_maint_engine;
   localparam int SETS = 64, WAYS = 2, TAG_W = 10, IDX_W = 6, VPN_W = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic cmd_page_wr = 0, cmd_page_inv = 0, cmd_all_wbinv = 0, cmd_all_inv = 0;
   logic [VPN_W-1:0] cmd_page_vpn = '0;
   logic stat_busy, stat_pf, xl_req;
   logic [VPN_W-1:0] xl_vpn;
   logic xl_rsp_valid = 0, xl_fault = 0;
   logic [VPN_W-1:0] xl_ppn = '0;
   logic tag_rd_en, tag_wr_en, wb_valid;
   logic wb_ready = 0;
   logic [IDX_W-1:0] tag_rd_idx, tag_wr_idx;
   logic [WAYS*TAG_W-1:0] tag_rd_tags = '0;
   logic [WAYS*2-1:0] tag_rd_states = '0;
   logic [WAYS-1:0] tag_wr_mask;
   logic [TAG_W+IDX_W-1:0] wb_addr;
   logic wb_way;

   pgm_maint_engine u0 (.*);

   int checks = 0, fails = 0, cyc = 0;
   logic [TAG_W-1:0] mtag [SETS][WAYS];
   logic [1:0] mst [SETS][WAYS];
   logic [1:0] est [SETS][WAYS];
   logic [TAG_W+IDX_W-1:0] exp_q [$];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // cache tag array model: registered read, write of Invalid into masked ways
   always @(posedge clk) begin
      if (tag_rd_en)
         for (int w = 0; w < WAYS; w++) begin
            tag_rd_tags[w*TAG_W +: TAG_W] <= mtag[tag_rd_idx][w];
            tag_rd_states[w*2 +: 2] <= mst[tag_rd_idx][w];
         end
      if (tag_wr_en)
         for (int w = 0; w < WAYS; w++)
            if (tag_wr_mask[w]) mst[tag_wr_idx][w] <= 2'b00;
   end

   // translation responder: two cycles of latency, upper nibble F faults
   int xl_wait = 0;
   always @(posedge clk) begin
      #1;
      if (xl_rsp_valid) begin
         xl_rsp_valid <= 0;
         xl_wait = 0;
      end else if (xl_req) begin
         xl_wait++;
         if (xl_wait == 2) begin
            xl_rsp_valid <= 1;
            xl_fault <= (xl_vpn[11:8] == 4'hF);
            xl_ppn <= xl_vpn ^ 12'h35C;
         end
      end else if (xl_wait != 0) begin
         chk(0, "R12", "request dropped before response", 0, 1);
         xl_wait = 0;
      end
   end

   // writeback ready pattern
   logic [7:0] lfsr = 8'h5B;
   always @(posedge clk) begin
      #1;
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wb_ready <= lfsr[0] | lfsr[3];
   end

   // scoreboard monitor
   always @(negedge clk) begin
      cyc++;
      if (rst_n && wb_valid && wb_ready) begin
         if (exp_q.size() == 0) chk(0, "R3", "unexpected writeback", wb_addr, 0);
         else begin
            logic [TAG_W+IDX_W-1:0] e;
            e = exp_q.pop_front();
            chk(wb_addr == e, "R2", "writeback address/order", wb_addr, e);
            chk(mst[wb_addr[IDX_W-1:0]][wb_way] == 2'b11, "R10",
                "line invalidated before writeback accepted",
                mst[wb_addr[IDX_W-1:0]][wb_way], 3);
         end
      end
   end

   task automatic report();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      wait (cyc > 150000);
      chk(0, "R6", "watchdog expired", cyc, 0);
      report();
   end

   task automatic fill(input logic [TAG_W-1:0] hot, input int seed);
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin
            mtag[s][w] = ((s + w + seed) % 3 != 0) ? hot : (hot ^ 10'h155);
            mst[s][w] = 2'((s * 3 + w * 5 + seed) % 4);
            est[s][w] = mst[s][w];
         end
   endtask

   task automatic expect_page(input logic [VPN_W-1:0] vpn, input bit inv);
      logic [VPN_W-1:0] p;
      logic [IDX_W-1:0] s;
      p = vpn ^ 12'h35C;
      if (vpn[11:8] == 4'hF) return;
      for (int k = 0; k < 16; k++) begin
         s = {p[1:0], 4'(k)};
         for (int w = 0; w < WAYS; w++)
            if (est[s][w] != 2'b00 && mtag[s][w] == p[11:2]) begin
               if (!inv && est[s][w] == 2'b11) exp_q.push_back({p[11:2], s});
               est[s][w] = 2'b00;
            end
      end
   endtask

   task automatic expect_all(input bit wb);
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin
            if (wb && est[s][w] == 2'b11) exp_q.push_back({mtag[s][w], 6'(s)});
            est[s][w] = 2'b00;
         end
   endtask

   task automatic pulse(input bit pg, input bit inv, input logic [VPN_W-1:0] vpn,
                        input bit awb, input bit ainv);
      @(posedge clk); #1;
      cmd_page_wr = pg; cmd_page_inv = inv; cmd_page_vpn = vpn;
      cmd_all_wbinv = awb; cmd_all_inv = ainv;
      @(posedge clk); #1;
      cmd_page_wr = 0; cmd_all_wbinv = 0; cmd_all_inv = 0;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (stat_busy);
   endtask

   task automatic compare(input string req);
      int bad = 0;
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) if (mst[s][w] != est[s][w]) bad++;
      chk(bad == 0, req, "mismatching line states", bad, 0);
      chk(exp_q.size() == 0, req, "writebacks still owed", exp_q.size(), 0);
   endtask

   task automatic page_op(input logic [VPN_W-1:0] vpn, input bit inv, input string req);
      expect_page(vpn, inv);
      pulse(1, inv, vpn, 0, 0);
      @(negedge clk);
      chk(stat_busy == 1, "R6", "busy after accept", stat_busy, 1);
      chk(stat_pf == 0, "R5", "fault flag cleared at start", stat_pf, 0);
      wait_done();
      compare(req);
   endtask

   initial begin
      logic [VPN_W-1:0] p;
      fill(10'h0D7, 0);
      repeat (5) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk(!stat_busy && !stat_pf && !wb_valid && !xl_req && !tag_wr_en, "R6",
          "reset state", {stat_busy, stat_pf, wb_valid, xl_req, tag_wr_en}, 0);

      // page flush: ppn = vpn ^ 35C, hot tag chosen to match
      p = 12'h123 ^ 12'h35C;
      fill(p[11:2], 1);
      page_op(12'h123, 0, "R2 R9");
      chk(stat_pf == 0, "R5", "fault flag after success", stat_pf, 0);

      // page invalidate
      p = 12'h2A6 ^ 12'h35C;
      fill(p[11:2], 2);
      page_op(12'h2A6, 1, "R3 R1");

      // fault: cache untouched, flag set
      fill(10'h0AA, 0);
      expect_page(12'hF12, 0);
      pulse(1, 0, 12'hF12, 0, 0);
      wait_done();
      chk(stat_pf == 1, "R4", "fault flag set", stat_pf, 1);
      compare("R4");

      // whole-cache op keeps the flag, and writes back every dirty line
      fill(10'h033, 1);
      expect_all(1);
      pulse(0, 0, '0, 1, 0);
      wait_done();
      chk(stat_pf == 1, "R5", "flag kept by whole-cache op", stat_pf, 1);
      compare("R7 R9");

      // next page op clears the flag
      p = 12'h071 ^ 12'h35C;
      fill(p[11:2], 3);
      page_op(12'h071, 0, "R2");

      // whole-cache invalidate only
      fill(10'h111, 2);
      expect_all(0);
      pulse(0, 0, '0, 0, 1);
      wait_done();
      compare("R8");

      // priority: page beats both whole-cache requests
      p = 12'h4B0 ^ 12'h35C;
      fill(p[11:2], 0);
      expect_page(12'h4B0, 0);
      pulse(1, 0, 12'h4B0, 1, 1);
      wait_done();
      compare("R11");
      // writeback-invalidate beats invalidate-only
      fill(10'h2C5, 3);
      expect_all(1);
      pulse(0, 0, '0, 1, 1);
      wait_done();
      compare("R11 R7");

      // request while busy is ignored
      p = 12'h555 ^ 12'h35C;
      fill(p[11:2], 1);
      expect_page(12'h555, 0);
      pulse(1, 0, 12'h555, 0, 0);
      repeat (3) @(posedge clk);
      #1 cmd_all_inv = 1;
      @(posedge clk); #1 cmd_all_inv = 0;
      wait_done();
      compare("R6");

      // request in the very cycle of the final tag write
      begin
         logic [IDX_W-1:0] last;
         bit saw_wr;
         p = 12'h6E9 ^ 12'h35C;
         last = {p[1:0], 4'hF};
         fill(p[11:2], 2);
         mtag[last][0] = p[11:2];
         mst[last][0] = 2'b01;
         est[last][0] = 2'b01;
         expect_page(12'h6E9, 1);
         pulse(1, 1, 12'h6E9, 0, 0);
         do @(negedge clk); while (!(tag_rd_en && tag_rd_idx == last));
         @(posedge clk); #1;
         @(posedge clk); #1 cmd_all_inv = 1;
         @(negedge clk);
         saw_wr = tag_wr_en && (tag_wr_idx == last);
         chk(saw_wr, "R6", "final write aligned with request", saw_wr, 1);
         @(posedge clk); #1 cmd_all_inv = 0;
         @(negedge clk);
         chk(stat_busy == 0, "R6", "busy after final write", stat_busy, 0);
         repeat (4) @(negedge clk);
         chk(stat_busy == 0, "R6", "late request dropped", stat_busy, 0);
         compare("R6 R3");
      end

      repeat (4) @(negedge clk);
      report();
   end
endmodule